// File: doc/BRIEF.md
# Output Drive Code Tracker

This block holds the binary drive-strength code applied to a set of output buffers and moves it toward the value that an external comparator indicates. On each clock the comparator reports one of three results: the driver is too weak (raise the code), too strong (lower the code), or matched. The block also receives the kind of bus cycle in progress. It changes the code only in cycles where the data pins are not being driven, which are writes and deselects. Each change is a single binary step, so the driver sees no large jump while it is in service.

After reset the code starts at mid-scale. A lock flag rises once the comparator has settled. Settled means it reports a match, or it keeps reversing direction around the target, for a programmable number of consecutive permitted cycles. A power-up window counter bounds the initial convergence. If the window expires without lock, a sticky timeout flag is raised.

Top module: `imp_code_stepper`

## Requirements
- R1: While reset (`rst_n` low) is applied and just after it is released, `code_o` is mid-scale (only the top bit set, 128 for an 8-bit code), and `locked_o` and `timeout_o` are 0.
- R2: `cyc_kind` encodes 2'b00 deselect, 2'b01 write, 2'b10 read; 2'b11 is treated as a read. The code changes only at a clock edge where `cyc_kind` is deselect or write. Read cycles leave it unchanged.
- R3: At a permitted edge the code rises by exactly one when only `cmp_up` is high and falls by exactly one when only `cmp_dn` is high. When both or neither are high it holds.
- R4: The code saturates: a raise at the all-ones code and a lower at zero leave it unchanged, with no wrap.
- R5: A permitted cycle counts as settled when it is a match, or when its direction is opposite to the previous requested step. A permitted cycle requesting the same direction as the previous step clears the count. Non-permitted cycles leave the count untouched. `locked_o` rises at the edge of the SETTLE_LEN-th consecutive settled cycle and stays high until reset.
- R6: If `locked_o` is not set by the WINDOW_CYCLES-th clock edge after reset release, `timeout_o` rises at that edge and stays high until reset.
- R7: If lock is reached before the window ends, `timeout_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_kind | input | 2 | Bus cycle type: 00 deselect, 01 write, 10/11 read |
| cmp_up | input | 1 | Comparator: driver too weak, raise the code |
| cmp_dn | input | 1 | Comparator: driver too strong, lower the code |
| code_o | output | CODE_W | Applied drive-strength code |
| locked_o | output | 1 | Calibration settled (sticky) |
| timeout_o | output | 1 | Power-up window expired without lock (sticky) |

## Verification
The bench builds the block with an 8-bit code, SETTLE_LEN of 3 and WINDOW_CYCLES of 200. The short window lets the timeout edge be hit cycle-exactly, and a full climb to the ceiling and descent to the floor each fit inside a run. The small settle length lets one vector table cover a lock, a count reset by a same-direction step, and reversals.

// File: rtl/imp_code_stepper.sv
module imp_code_stepper #(
  parameter int CODE_W        = 8,
  parameter int SETTLE_LEN    = 16,
  parameter int WINDOW_CYCLES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cyc_kind,
  input  logic              cmp_up,
  input  logic              cmp_dn,
  output logic [CODE_W-1:0] code_o,
  output logic              locked_o,
  output logic              timeout_o
);
  localparam int SW = $clog2(SETTLE_LEN + 1);
  localparam int WW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [SW-1:0] SET_MAX = SW'(SETTLE_LEN);
  localparam logic [WW-1:0] WIN_MAX = WW'(WINDOW_CYCLES);

  logic [CODE_W-1:0] code_q, code_nxt;
  logic [SW-1:0]     set_q, set_nxt;
  logic [WW-1:0]     win_q;
  logic              have_dir_q, last_dn_q, locked_q, to_q;

  wire permit   = ~cyc_kind[1];
  wire go_up    = cmp_up & ~cmp_dn;
  wire go_dn    = cmp_dn & ~cmp_up;
  wire reversal = have_dir_q & ((go_up & last_dn_q) | (go_dn & ~last_dn_q));
  wire settled  = ~(go_up | go_dn) | reversal;
  wire lock_nxt = locked_q | (set_nxt == SET_MAX);
  wire win_end  = (win_q == WIN_MAX - WW'(1));

  always_comb begin
    code_nxt = code_q;
    if (permit && go_up && !(&code_q)) code_nxt = code_q + CODE_W'(1);
    if (permit && go_dn && (|code_q))  code_nxt = code_q - CODE_W'(1);
  end

  always_comb begin
    set_nxt = set_q;
    if (permit) begin
      if (!settled)             set_nxt = '0;
      else if (set_q != SET_MAX) set_nxt = set_q + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q     <= MID;
      set_q      <= '0;
      win_q      <= '0;
      have_dir_q <= 1'b0;
      last_dn_q  <= 1'b0;
      locked_q   <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      code_q   <= code_nxt;
      set_q    <= set_nxt;
      locked_q <= lock_nxt;
      if (win_q != WIN_MAX) win_q <= win_q + WW'(1);
      if (win_end && !lock_nxt) to_q <= 1'b1;
      if (permit && (go_up || go_dn)) begin
        have_dir_q <= 1'b1;
        last_dn_q  <= go_dn;
      end
    end
  end

  assign code_o    = code_q;
  assign locked_o  = locked_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/imp_code_stepper_chk.sv
module imp_code_stepper_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cyc_kind,
  input logic              cmp_up,
  input logic              cmp_dn,
  input logic [CODE_W-1:0] code_o,
  input logic              locked_o,
  input logic              timeout_o
);
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_kind[1] |=> $stable(code_o)); // R2

  AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_up == cmp_dn) |=> $stable(code_o)); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((code_o == $past(code_o)) || (code_o == $past(code_o) + CODE_W'(1))
              || (code_o + CODE_W'(1) == $past(code_o)))); // R3

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (&code_o) |=> (code_o != '0)); // R4

  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '0) |=> !(&code_o)); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o); // R5

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> timeout_o); // R6

  AST_NO_TIMEOUT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> !locked_o); // R7
endmodule

bind imp_code_stepper imp_code_stepper_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .cmp_up(cmp_up), .cmp_dn(cmp_dn),
  .code_o(code_o), .locked_o(locked_o), .timeout_o(timeout_o)
);

// File: tb/imp_code_stepper_tb_top.sv
module imp_code_stepper_tb_top;
  localparam int CW = 8;
  localparam int SL = 3;
  localparam int WC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cyc_kind = 2'b10;
  logic cmp_up = 1'b0, cmp_dn = 1'b0;
  logic [CW-1:0] code_o;
  logic locked_o, timeout_o;
  int n_chk = 0, n_fail = 0;

  always #4ns clk = ~clk;

  imp_code_stepper #(.CODE_W(CW), .SETTLE_LEN(SL), .WINDOW_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .cmp_up(cmp_up), .cmp_dn(cmp_dn),
    .code_o(code_o), .locked_o(locked_o), .timeout_o(timeout_o));

  // {kind[1:0], up, dn, expected code[7:0], expected locked}
  localparam logic [12:0] VEC [12] = '{
    {2'b01, 1'b1, 1'b0, 8'd129, 1'b0},  // R3 write up
    {2'b10, 1'b0, 1'b1, 8'd129, 1'b0},  // R2 read ignored
    {2'b00, 1'b1, 1'b0, 8'd130, 1'b0},  // R2 deselect permitted
    {2'b01, 1'b0, 1'b1, 8'd129, 1'b0},  // R5 reversal 1
    {2'b01, 1'b1, 1'b0, 8'd130, 1'b0},  // R5 reversal 2
    {2'b01, 1'b1, 1'b0, 8'd131, 1'b0},  // R5 same dir clears
    {2'b01, 1'b0, 1'b0, 8'd131, 1'b0},  // R3 match holds
    {2'b10, 1'b0, 1'b0, 8'd131, 1'b0},  // R5 read keeps count
    {2'b01, 1'b1, 1'b1, 8'd131, 1'b0},  // R3 both = match
    {2'b11, 1'b1, 1'b0, 8'd131, 1'b0},  // R2 kind 11 as read
    {2'b00, 1'b0, 1'b1, 8'd130, 1'b1},  // R5 third settled -> lock
    {2'b01, 1'b1, 1'b0, 8'd131, 1'b1}   // R5 lock sticky
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] k, input logic u, input logic d);
    cyc_kind = k; cmp_up = u; cmp_dn = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc_kind = 2'b10; cmp_up = 1'b0; cmp_dn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 code in reset", int'(code_o), 128);
    rst_n = 1'b1;
    check("R1 code", int'(code_o), 128);
    check("R1 locked", int'(locked_o), 0);
    check("R1 timeout", int'(timeout_o), 0);
  endtask

  initial begin
    #800us;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 12; i++) begin
      cyc(VEC[i][12:11], VEC[i][10], VEC[i][9]);
      check($sformatf("R2/R3/R5 vec%0d code", i), int'(code_o), int'(VEC[i][8:1]));
      check($sformatf("R5 vec%0d locked", i), int'(locked_o), int'(VEC[i][0]));
    end
    repeat (200) cyc(2'b10, 1'b0, 1'b0);
    check("R7 no timeout after lock", int'(timeout_o), 0);

    do_reset();
    repeat (140) cyc(2'b01, 1'b1, 1'b0);
    check("R4 top saturation", int'(code_o), 255);
    check("R5 no lock on one-way climb", int'(locked_o), 0);
    repeat (59) cyc(2'b10, 1'b0, 1'b0);
    check("R6 timeout before window end", int'(timeout_o), 0);
    cyc(2'b10, 1'b0, 1'b0);
    check("R6 timeout at window end", int'(timeout_o), 1);
    repeat (5) cyc(2'b01, 1'b0, 1'b0);
    check("R6 timeout sticky", int'(timeout_o), 1);

    do_reset();
    repeat (140) cyc(2'b00, 1'b0, 1'b1);
    check("R4 bottom saturation", int'(code_o), 0);
    cyc(2'b01, 1'b1, 1'b0);
    check("R3 step up from floor", int'(code_o), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule